// File: doc/BRIEF.md
# Dual-Loop Synthesizer Serial Programming Loader

This block receives programming words for a two-loop frequency synthesizer over a short serial link and presents the decoded settings as parallel register outputs. The link has a serial clock, a load-enable line, a main data pin and a second data pin. The level of the load-enable line while bits are clocked in selects the destination. When it is high, the word goes to the control/reference pair. When it is low, the word goes to the transmit/receive divider pair. The divider counters, phase detectors and oscillator that use these values are outside the block.

All link inputs are brought into the system clock domain through a synchronizer, and edges are detected there. A word sent with the enable line high is committed when that line falls. The first bit of such a word, together with its exact length, tells a short control word apart from a long reference word. Transmit/receive bits are gathered while the enable line is low and are committed by a later high pulse on that line during which no clock edges occur. A stored control bit selects how those bits arrive. In one-pin mode both halves arrive in turn on the main pin. In two-pin mode the two halves arrive side by side, which halves the load time. A transfer with the wrong length is dropped and raises an error flag.

Top module: `synth_prog_loader`

## Requirements
- R1: A data bit is taken only on a rising edge of `serClk`, and words are sent most significant bit first. Data that changes while `serClk` is high or low without a rising edge has no effect.
- R2: A transfer made with `latchEn` high whose first bit is 1 and whose length is exactly 8 bits is a control word. On commit, bit 6 of the word sets `dualPinMode` and bits 5..0 set `ctrlBits`. Bit 7 is the leading 1.
- R3: A transfer made with `latchEn` high whose first bit is 0 and whose length is exactly 32 bits is a reference word. Bits 13..2 go to `refDiv`, bits 27..14 go to `auxRefDiv` and bit 1 goes to `refSel`. Bits 30..28 are ignored.
- R4: Bit 0 of the reference word sets `auxRefEn`. A value of 1 runs the auxiliary reference counter, and a value of 0 holds that counter powered down.
- R5: Held register outputs change only in response to a falling edge of `latchEn`. Bits that have been shifted but not yet committed leave the outputs unchanged.
- R6: With `dualPinMode` at 0, a transmit/receive load is 32 bits on `dataIn`. The first 16 bits are the transmit value and the next 16 are the receive value.
- R7: With `dualPinMode` at 1, a transmit/receive load takes 16 clocks. The transmit value arrives on `auxDataIn` and the receive value arrives on `dataIn` in the same clocks.
- R8: A high pulse on `latchEn` with no `serClk` rising edge during it commits the collected transmit/receive bits to `txDiv` and `rxDiv`. This commit leaves the control and reference outputs unchanged.
- R9: A transfer of the wrong length is discarded. The wrong lengths are a control word not 8 bits long, a reference word not 32 bits long, and a transmit/receive load not 32 (one-pin) or 16 (two-pin) bits long, including zero bits. A discarded transfer sets `loadErr`, which stays set until the next successful commit of any kind.
- R10: After reset, every output is 0, one-pin mode is in force and `loadErr` is 0.
- R11: A control commit leaves the reference outputs unchanged, and a reference commit leaves `ctrlBits` and `dualPinMode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all link inputs are sampled on it |
| rstN | input | 1 | Active-low reset |
| serClk | input | 1 | Serial bit clock; a rising edge takes one bit |
| latchEn | input | 1 | Destination select while shifting; its falling edge commits |
| dataIn | input | 1 | Main serial data pin |
| auxDataIn | input | 1 | Second serial data pin, used for the transmit value in two-pin mode |
| ctrlBits | output | 6 | General control bits from the last control word |
| dualPinMode | output | 1 | 1 selects two-pin transmit/receive loading |
| refDiv | output | 12 | Reference divide value |
| auxRefDiv | output | 14 | Auxiliary reference divide value |
| refSel | output | 1 | Reference selection bit |
| auxRefEn | output | 1 | 1 runs the auxiliary reference counter, 0 powers it down |
| txDiv | output | 16 | Transmit divide value |
| rxDiv | output | 16 | Receive divide value |
| loadErr | output | 1 | Set by a discarded transfer, cleared by a good commit |

## Verification
The hardest case to reach from the pins is a falling edge of `latchEn` whose meaning depends on history. Whether it is a transmit/receive strobe, a control or reference commit, or a rejected transfer depends on how many serial clocks came before it, in which enable phase, and under which stored pin mode. The stimulus reaches these cases by first writing a control word to set the mode. It then sends loads one bit short, full-length words with the wrong leading bit, and bare strobes with no data behind them. Between such loads it sends correct ones, and it checks that the held outputs and the error flag change only as the rules above allow. Every serial bit is inverted while the serial clock sits high, so an implementation that samples on the wrong edge loads the complement.

// File: rtl/synth_load_pkg.sv
package synth_load_pkg;

  // Strobes issued by the sequencing control to the register datapath.
  typedef struct packed {
    logic shiftCr;     // shift one bit into the control/reference shifter
    logic shiftTr;     // shift one bit (or one pair) into the tx/rx shifter
    logic commitCtrl;  // copy the short word into the control holding bits
    logic commitRef;   // copy the long word into the reference holding bits
    logic commitTr;    // copy the tx/rx shifter into the divider outputs
  } load_strobe_t;

endpackage

// File: rtl/synth_load_sync.sv
module synth_load_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign syncOut = asyncIn;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage <= '0;
        end else begin
          stage[0] <= asyncIn;
          for (int i = 1; i < STAGES; i++) begin
            stage[i] <= stage[i-1];
          end
        end
      end

      assign syncOut = stage[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/synth_load_ctrl.sv
module synth_load_ctrl
  import synth_load_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int REF_W  = 32,
  parameter int DIV_W  = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkS,
  input  logic         enbS,
  input  logic         dinS,
  input  logic         dualMode,
  output load_strobe_t str,
  output logic         loadErr
);

  localparam int CNT_W = $clog2(2 * DIV_W + REF_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CTRL_N  = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] REF_N   = CNT_W'(REF_W);
  localparam logic [CNT_W-1:0] TR_ONE  = CNT_W'(2 * DIV_W);
  localparam logic [CNT_W-1:0] TR_TWO  = CNT_W'(DIV_W);

  logic             sclkQ;
  logic             enbQ;
  logic [CNT_W-1:0] crCount;
  logic [CNT_W-1:0] trCount;
  logic             firstBit;
  logic             errQ;

  logic             sclkRise;
  logic             enbFall;
  logic             badWord;
  logic [CNT_W-1:0] trExpect;

  assign sclkRise = sclkS & ~sclkQ;
  assign enbFall  = enbQ & ~enbS;
  assign trExpect = dualMode ? TR_TWO : TR_ONE;

  // Decode of the serial events into strobes.
  always_comb begin
    str     = '0;
    badWord = 1'b0;
    if (sclkRise) begin
      if (enbS) str.shiftCr = 1'b1;
      else      str.shiftTr = 1'b1;
    end
    if (enbFall) begin
      if (crCount == '0) begin
        // bare enable pulse: strobe for the transmit/receive pair
        if (trCount == trExpect) str.commitTr = 1'b1;
        else                     badWord      = 1'b1;
      end else if (firstBit && (crCount == CTRL_N)) begin
        str.commitCtrl = 1'b1;
      end else if (!firstBit && (crCount == REF_N)) begin
        str.commitRef = 1'b1;
      end else begin
        badWord = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      enbQ     <= 1'b0;
      crCount  <= '0;
      trCount  <= '0;
      firstBit <= 1'b0;
    end else begin
      sclkQ <= sclkS;
      enbQ  <= enbS;
      if (enbFall) begin
        crCount <= '0;
        trCount <= '0;
      end else begin
        if (str.shiftCr) begin
          if (crCount == '0) firstBit <= dinS;
          if (crCount != CNT_MAX) crCount <= crCount + 1'b1;
        end
        if (str.shiftTr && (trCount != CNT_MAX)) begin
          trCount <= trCount + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
    end else if (badWord) begin
      errQ <= 1'b1;
    end else if (str.commitCtrl || str.commitRef || str.commitTr) begin
      errQ <= 1'b0;
    end
  end

  assign loadErr = errQ;

  // R9: the error flag can only rise right after an enable falling edge
  assert_err_on_fall_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
      $rose(errQ) |-> $past(enbFall)
  ) else $error("error flag rose without an enable falling edge");

  // R9: any successful commit clears the error flag
  assert_commit_clears_err_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
      (str.commitCtrl || str.commitRef || str.commitTr) |=> !errQ
  ) else $error("error flag survived a good commit");

  // R5: every enable falling edge starts a fresh transfer
  assert_fall_restarts_R5 : assert property (
    @(posedge clk) disable iff (!rstN)
      enbFall |=> (crCount == '0) && (trCount == '0)
  ) else $error("bit counters not cleared after enable fall");

  // R1: a serial clock rising edge with enable high is always counted
  assert_rise_counted_R1 : assert property (
    @(posedge clk) disable iff (!rstN)
      (sclkRise && enbS && !enbFall) |=> (crCount != '0)
  ) else $error("rising serial clock was not counted");

endmodule

// File: rtl/synth_load_datapath.sv
module synth_load_datapath
  import synth_load_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int REF_W    = 32,
  parameter int DIV_W    = 16,
  parameter int REFDIV_W = 12,
  parameter int AUXDIV_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  load_strobe_t        str,
  input  logic                dinS,
  input  logic                adinS,
  output logic [CTRL_W-3:0]   ctrlBits,
  output logic                dualMode,
  output logic [REFDIV_W-1:0] refDiv,
  output logic [AUXDIV_W-1:0] auxRefDiv,
  output logic                refSel,
  output logic                auxRefEn,
  output logic [DIV_W-1:0]    txDiv,
  output logic [DIV_W-1:0]    rxDiv
);

  localparam int TR_W     = 2 * DIV_W;
  localparam int MODE_BIT = CTRL_W - 2;
  localparam int REF_LO   = 2;
  localparam int REF_HI   = REF_LO + REFDIV_W - 1;
  localparam int AUX_LO   = REF_HI + 1;
  localparam int AUX_HI   = AUX_LO + AUXDIV_W - 1;

  logic [REF_W-1:0] crSh;
  logic [TR_W-1:0]  trSh;

  // Control/reference shifter: always one pin.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            crSh <= '0;
    else if (str.shiftCr) crSh <= {crSh[REF_W-2:0], dinS};
  end

  // Transmit/receive shifter: one long chain or two side-by-side halves.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trSh <= '0;
    end else if (str.shiftTr) begin
      if (dualMode) begin
        trSh <= {trSh[TR_W-2:DIV_W], adinS, trSh[DIV_W-2:0], dinS};
      end else begin
        trSh <= {trSh[TR_W-2:0], dinS};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBits <= '0;
      dualMode <= 1'b0;
    end else if (str.commitCtrl) begin
      ctrlBits <= crSh[CTRL_W-3:0];
      dualMode <= crSh[MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refDiv    <= '0;
      auxRefDiv <= '0;
      refSel    <= 1'b0;
      auxRefEn  <= 1'b0;
    end else if (str.commitRef) begin
      refDiv    <= crSh[REF_HI:REF_LO];
      auxRefDiv <= crSh[AUX_HI:AUX_LO];
      refSel    <= crSh[1];
      auxRefEn  <= crSh[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDiv <= '0;
      rxDiv <= '0;
    end else if (str.commitTr) begin
      txDiv <= trSh[TR_W-1:DIV_W];
      rxDiv <= trSh[DIV_W-1:0];
    end
  end

  // R8: a transmit/receive commit leaves control and reference alone
  assert_tr_keeps_cr_R8 : assert property (
    @(posedge clk) disable iff (!rstN)
      str.commitTr |=> $stable(refDiv) && $stable(auxRefDiv) &&
                       $stable(ctrlBits) && $stable(dualMode)
  ) else $error("tx/rx commit disturbed control or reference");

  // R5: reference outputs hold unless a reference commit is strobed
  assert_ref_hold_R5 : assert property (
    @(posedge clk) disable iff (!rstN)
      !str.commitRef |=> $stable(refDiv) && $stable(auxRefDiv) &&
                         $stable(refSel) && $stable(auxRefEn)
  ) else $error("reference outputs moved without a commit");

  // R5: divider outputs hold unless a tx/rx commit is strobed
  assert_tr_hold_R5 : assert property (
    @(posedge clk) disable iff (!rstN)
      !str.commitTr |=> $stable(txDiv) && $stable(rxDiv)
  ) else $error("divider outputs moved without a commit");

  // R11: a control commit leaves reference fields untouched
  assert_ctrl_keeps_ref_R11 : assert property (
    @(posedge clk) disable iff (!rstN)
      str.commitCtrl |=> $stable(refDiv) && $stable(auxRefEn)
  ) else $error("control commit disturbed reference");

  // R2: shifting never happens to both shifters in one cycle
  assert_one_shift_R2 : assert property (
    @(posedge clk) disable iff (!rstN)
      $onehot0({str.shiftCr, str.shiftTr, str.commitCtrl, str.commitRef})
  ) else $error("conflicting strobes");

endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_load_pkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int REF_W       = 32,
  parameter int DIV_W       = 16,
  parameter int REFDIV_W    = 12,
  parameter int AUXDIV_W    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClk,
  input  logic                latchEn,
  input  logic                dataIn,
  input  logic                auxDataIn,
  output logic [CTRL_W-3:0]   ctrlBits,
  output logic                dualPinMode,
  output logic [REFDIV_W-1:0] refDiv,
  output logic [AUXDIV_W-1:0] auxRefDiv,
  output logic                refSel,
  output logic                auxRefEn,
  output logic [DIV_W-1:0]    txDiv,
  output logic [DIV_W-1:0]    rxDiv,
  output logic                loadErr
);

  localparam int FIELD_BITS = REFDIV_W + AUXDIV_W + 3;

  logic [3:0]   syncd;
  load_strobe_t str;

  initial begin
    assert (REF_W >= FIELD_BITS)
      else $error("reference word too short for its fields");
  end

  synth_load_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serClk, latchEn, dataIn, auxDataIn}),
    .syncOut (syncd)
  );

  synth_load_ctrl #(
    .CTRL_W (CTRL_W),
    .REF_W  (REF_W),
    .DIV_W  (DIV_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkS    (syncd[3]),
    .enbS     (syncd[2]),
    .dinS     (syncd[1]),
    .dualMode (dualPinMode),
    .str      (str),
    .loadErr  (loadErr)
  );

  synth_load_datapath #(
    .CTRL_W   (CTRL_W),
    .REF_W    (REF_W),
    .DIV_W    (DIV_W),
    .REFDIV_W (REFDIV_W),
    .AUXDIV_W (AUXDIV_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .dinS      (syncd[1]),
    .adinS     (syncd[0]),
    .ctrlBits  (ctrlBits),
    .dualMode  (dualPinMode),
    .refDiv    (refDiv),
    .auxRefDiv (auxRefDiv),
    .refSel    (refSel),
    .auxRefEn  (auxRefEn),
    .txDiv     (txDiv),
    .rxDiv     (rxDiv)
  );

  // R9: a discarded transfer never coincides with a commit
  assert_err_no_commit_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
      $rose(loadErr) |-> $stable(txDiv) && $stable(refDiv) && $stable(ctrlBits)
  ) else $error("error raised while outputs changed");

endmodule

// File: tb/tb_synth_prog_loader.sv
module tb_synth_prog_loader;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        latchEn = 1'b0;
  logic        dataIn = 1'b0;
  logic        auxDataIn = 1'b0;
  logic [5:0]  ctrlBits;
  logic        dualPinMode;
  logic [11:0] refDiv;
  logic [13:0] auxRefDiv;
  logic        refSel;
  logic        auxRefEn;
  logic [15:0] txDiv;
  logic [15:0] rxDiv;
  logic        loadErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  synth_prog_loader dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .latchEn(latchEn),
    .dataIn(dataIn), .auxDataIn(auxDataIn), .ctrlBits(ctrlBits),
    .dualPinMode(dualPinMode), .refDiv(refDiv), .auxRefDiv(auxRefDiv),
    .refSel(refSel), .auxRefEn(auxRefEn), .txDiv(txDiv), .rxDiv(rxDiv),
    .loadErr(loadErr)
  );

  // {mode, tx, rx}; mode 1 = two-pin
  localparam logic [32:0] TR_VEC [6] = '{
    {1'b0, 16'h1234, 16'hABCD},
    {1'b1, 16'h0F0F, 16'hF0F0},
    {1'b1, 16'hFFFF, 16'h0001},
    {1'b0, 16'h8000, 16'h7FFF},
    {1'b0, 16'h0000, 16'hFFFF},
    {1'b1, 16'h5A5A, 16'hA5A5}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refWord(input logic [13:0] aux,
      input logic [11:0] rd, input logic sel, input logic en);
    return {1'b0, 3'b101, aux, rd, sel, en};
  endfunction

  // data is inverted while serClk is high (R1)
  task automatic serShift(input logic [31:0] mw, input logic [31:0] aw, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      dataIn = mw[i];
      auxDataIn = aw[i];
      repeat (HALF) @(negedge clk);
      serClk = 1'b1;
      repeat (2) @(negedge clk);
      dataIn = ~mw[i];
      auxDataIn = ~aw[i];
      repeat (HALF - 2) @(negedge clk);
      serClk = 1'b0;
    end
  endtask

  task automatic crWrite(input logic [31:0] w, input int n);
    latchEn = 1'b1;
    repeat (HALF) @(negedge clk);
    serShift(w, 32'h0, n);
    repeat (HALF) @(negedge clk);
    latchEn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe();
    repeat (HALF) @(negedge clk);
    latchEn = 1'b1;
    repeat (HALF) @(negedge clk);
    latchEn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic trWrite(input logic dual, input logic [15:0] tx,
                         input logic [15:0] rx, input int n);
    if (dual) serShift({16'h0, rx}, {16'h0, tx}, n);
    else      serShift({tx, rx}, 32'h0, n);
    strobe();
  endtask

  task automatic setMode(input logic dual, input logic [5:0] cb);
    crWrite({24'h0, 1'b1, dual, cb}, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [11:0] rdSave;
    logic [15:0] txSave;
    logic [5:0]  cbSave;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check({ctrlBits, dualPinMode, refDiv, auxRefDiv, refSel, auxRefEn,
           txDiv, rxDiv, loadErr} == '0, "R10 reset outputs",
          {ctrlBits, refDiv, txDiv, rxDiv}, 0);

    // R3 R4 reference word
    crWrite(refWord(14'h2A5C, 12'hB3D, 1'b1, 1'b1), 32);
    check(refDiv == 12'hB3D, "R3 refDiv", refDiv, 12'hB3D);
    check(auxRefDiv == 14'h2A5C, "R3 auxRefDiv", auxRefDiv, 14'h2A5C);
    check(refSel == 1'b1, "R3 refSel", refSel, 1);
    check(auxRefEn == 1'b1, "R4 aux counter running", auxRefEn, 1);

    // R2 control word, R11 reference untouched
    setMode(1'b0, 6'h2A);
    check(ctrlBits == 6'h2A, "R2 ctrlBits", ctrlBits, 6'h2A);
    check(dualPinMode == 1'b0, "R2 mode bit", dualPinMode, 0);
    check(refDiv == 12'hB3D && auxRefEn, "R11 ref kept by ctrl", refDiv, 12'hB3D);

    // vector table: R6 one-pin, R7 two-pin, R8 ref/ctrl untouched
    for (int v = 0; v < 6; v++) begin
      logic dual;
      dual = TR_VEC[v][32];
      if (dual != dualPinMode) begin
        setMode(dual, 6'h2A);
        check(dualPinMode == dual, "R2 mode switch", dualPinMode, dual);
      end
      trWrite(dual, TR_VEC[v][31:16], TR_VEC[v][15:0], dual ? 16 : 32);
      check(txDiv == TR_VEC[v][31:16], dual ? "R7 txDiv" : "R6 txDiv",
            txDiv, TR_VEC[v][31:16]);
      check(rxDiv == TR_VEC[v][15:0], dual ? "R7 rxDiv" : "R6 rxDiv",
            rxDiv, TR_VEC[v][15:0]);
      check(refDiv == 12'hB3D && ctrlBits == 6'h2A && !loadErr,
            "R8 ctrl/ref kept by tx/rx", {ctrlBits, refDiv}, {6'h2A, 12'hB3D});
    end

    // R5: shifted but uncommitted reference bits do not show
    latchEn = 1'b1;
    repeat (HALF) @(negedge clk);
    serShift(refWord(14'h0111, 12'h0F0, 1'b0, 1'b0), 32'h0, 32);
    repeat (8) @(negedge clk);
    check(refDiv == 12'hB3D, "R5 held before fall", refDiv, 12'hB3D);
    latchEn = 1'b0;
    repeat (8) @(negedge clk);
    check(refDiv == 12'h0F0 && auxRefDiv == 14'h0111, "R5 commit on fall",
          refDiv, 12'h0F0);
    check(auxRefEn == 1'b0 && refSel == 1'b0, "R4 aux counter powered down",
          auxRefEn, 0);
    check(ctrlBits == 6'h2A && dualPinMode == 1'b1, "R11 ctrl kept by ref",
          {dualPinMode, ctrlBits}, {1'b1, 6'h2A});

    // R9: two-pin load sent as 32 clocks is rejected
    txSave = txDiv;
    trWrite(1'b1, 16'h1111, 16'h2222, 32);
    check(loadErr == 1'b1, "R9 long two-pin load flagged", loadErr, 1);
    check(txDiv == txSave, "R9 long load discarded", txDiv, txSave);

    // R9: good load clears flag
    trWrite(1'b1, 16'hC001, 16'h0C0D, 16);
    check(loadErr == 1'b0 && txDiv == 16'hC001, "R9 flag cleared by good load",
          {loadErr, txDiv}, {1'b0, 16'hC001});

    // R9: bare strobe with no bits behind it
    strobe();
    check(loadErr == 1'b1 && txDiv == 16'hC001, "R9 empty strobe rejected",
          {loadErr, txDiv}, {1'b1, 16'hC001});

    // R9: one-pin load one bit short
    setMode(1'b0, 6'h15);
    check(loadErr == 1'b0 && ctrlBits == 6'h15, "R9 ctrl commit clears flag",
          {loadErr, ctrlBits}, {1'b0, 6'h15});
    trWrite(1'b0, 16'hDEAD, 16'hBEEF, 31);
    check(loadErr == 1'b1 && rxDiv == 16'h0C0D, "R9 short one-pin load",
          {loadErr, rxDiv}, {1'b1, 16'h0C0D});

    // R9: seven-bit control word
    cbSave = ctrlBits;
    crWrite({25'h0, 1'b1, 6'h3F}, 7);
    check(loadErr == 1'b1 && ctrlBits == cbSave, "R9 short ctrl word",
          {loadErr, ctrlBits}, {1'b1, cbSave});

    // R9: reference word one bit short
    rdSave = refDiv;
    crWrite(refWord(14'h3FFF, 12'hFFF, 1'b1, 1'b1) >> 1, 31);
    check(loadErr == 1'b1 && refDiv == rdSave, "R9 short ref word",
          {loadErr, refDiv}, {1'b1, rdSave});

    // R9: eight bits with a leading zero match neither word
    crWrite({24'h0, 8'h7F}, 8);
    check(loadErr == 1'b1 && ctrlBits == cbSave && refDiv == rdSave,
          "R9 wrong leading bit", {ctrlBits, refDiv}, {cbSave, rdSave});

    // R1 R6: one-pin load after errors, data flipped while clock high
    trWrite(1'b0, 16'hA0A0, 16'h0505, 32);
    check(txDiv == 16'hA0A0 && rxDiv == 16'h0505 && !loadErr,
          "R1 rising-edge sampling", {txDiv, rxDiv}, {16'hA0A0, 16'h0505});

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule